// File: doc/BRIEF.md
# FIFO-to-Bus Burst Drain Controller

This block sits on the bus side of an acquisition data path. It uses the buffer clock of a bus bridge to move 32-bit words out of the read port of an external FIFO and into the bridge's internal write FIFO. Words move one per clock. The data itself never passes through the block: it only drives the two strobes that pace the transfer.

The controller waits while the external FIFO is mostly empty. When the FIFO reports that it is nearly full and the bridge can take data, a burst starts. The read enable of the FIFO and the write enable of the bridge rise together on that edge. The burst runs until the bridge reports full or the FIFO reports that it is nearly drained, so the two thresholds give the start and stop decisions hysteresis.

The two FIFO flags are active low and the bridge flag is active high. A saturating counter reports how many words the current or most recent burst has moved.

Top module: `fifo_burst_drain`

## Requirements
- R1: While `rst` is high at a rising edge, both strobes go low and `burst_words` goes to 0 from that edge, and the controller is idle.
- R2: When idle, if `xfifo_fill_n` is 0 and `bridge_full` is 0 at a rising edge, `xfifo_oe` and `bridge_we` are both 1 from that edge onward.
- R3: When idle, no burst starts if `xfifo_fill_n` is 1 or `bridge_full` is 1. The value of `xfifo_low_n` has no effect while idle.
- R4: In a burst, if `xfifo_low_n` is 0 at a rising edge, both strobes are 0 from that edge.
- R5: In a burst, if `bridge_full` is 1 at a rising edge, both strobes are 0 from that edge. This also holds when `xfifo_low_n` is 0 at the same time.
- R6: In a burst, while `xfifo_low_n` is 1 and `bridge_full` is 0, both strobes stay at 1, whatever `xfifo_fill_n` does.
- R7: `xfifo_oe` and `bridge_we` are equal in every cycle.
- R8: `burst_words` becomes 0 on the edge that starts a burst. It then rises by one on every edge where the strobes were 1 before that edge. It holds its value after the burst ends, until the next burst starts.
- R9: `burst_words` saturates at 2^COUNT_W-1 and stays there for the rest of a long burst.
- R10: A burst may start while `xfifo_low_n` is already 0. It then stops on the next edge, after exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge buffer clock |
| rst | input | 1 | Synchronous reset, active high |
| xfifo_fill_n | input | 1 | External FIFO almost-full flag, active low |
| xfifo_low_n | input | 1 | External FIFO almost-empty flag, active low |
| bridge_full | input | 1 | Bridge write FIFO full flag, active high |
| xfifo_oe | output | 1 | External FIFO read/output enable, active high, registered |
| bridge_we | output | 1 | Bridge FIFO write enable, active high, registered |
| burst_words | output | COUNT_W | Words moved in the current or last burst |

## Verification
Two functions can fall in the same cycle: the two stop causes, the bridge filling and the FIFO reaching its low mark. Start and stop can also coincide, when a burst is triggered while the low mark is already asserted. The bench drives both stop flags active on the same low clock phase during a burst. It requires that the strobes fall on the next edge exactly once and that the word count shows the cycles the strobes were high. It also starts a burst with the low mark already asserted, and expects one strobe cycle and a count of one.

// File: rtl/drain_pkg.sv
package drain_pkg;

  // Controller state: waiting for a fill trigger, or moving words.
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } drain_state_t;

  // Normalised flag bundle, all fields active high.
  typedef struct packed {
    logic src_near_full;
    logic src_near_empty;
    logic dst_full;
  } drain_flags_t;

endpackage

// File: rtl/drain_flag_decode.sv
module drain_flag_decode
  import drain_pkg::*;
(
  input  logic         fill_n,
  input  logic         low_n,
  input  logic         dst_full,
  output drain_flags_t flags,
  output logic         start_ok,
  output logic         stop_req
);

  // Mixed pin polarity resolved in one place.
  always_comb begin
    flags.src_near_full  = ~fill_n;
    flags.src_near_empty = ~low_n;
    flags.dst_full       = dst_full;
  end

  // Start needs data waiting and room downstream; either end stops a burst.
  assign start_ok = flags.src_near_full & ~flags.dst_full;
  assign stop_req = flags.src_near_empty | flags.dst_full;

endmodule

// File: rtl/drain_fsm.sv
module drain_fsm
  import drain_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_ok,
  input  logic stop_req,
  output logic rd_en,
  output logic wr_en,
  output logic enter_burst
);

  drain_state_t state_q, state_d;
  logic         rd_q, wr_q;

  always_comb begin
    state_d     = state_q;
    enter_burst = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d     = ST_BURST;
          enter_burst = 1'b1;
        end
      end
      ST_BURST: begin
        if (stop_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Both strobes are registered from the same next state, so they switch on one edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= (state_d == ST_BURST);
      wr_q    <= (state_d == ST_BURST);
    end
  end

  assign rd_en = rd_q;
  assign wr_en = wr_q;

endmodule

// File: rtl/drain_word_counter.sv
module drain_word_counter #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               moved,
  output logic [COUNT_W-1:0] count
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  logic [COUNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (moved && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/fifo_burst_drain.sv
module fifo_burst_drain #(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xfifo_fill_n,
  input  logic               xfifo_low_n,
  input  logic               bridge_full,
  output logic               xfifo_oe,
  output logic               bridge_we,
  output logic [COUNT_W-1:0] burst_words
);

  import drain_pkg::*;

  drain_flags_t flags;
  logic         start_ok;
  logic         stop_req;
  logic         enter_burst;
  logic         rd_en;
  logic         wr_en;

  drain_flag_decode u_decode (
    .fill_n   (xfifo_fill_n),
    .low_n    (xfifo_low_n),
    .dst_full (bridge_full),
    .flags    (flags),
    .start_ok (start_ok),
    .stop_req (stop_req)
  );

  drain_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_ok    (start_ok),
    .stop_req    (stop_req),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .enter_burst (enter_burst)
  );

  // A word moves on every edge where the write strobe was high.
  drain_word_counter #(.COUNT_W(COUNT_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clear (enter_burst),
    .moved (wr_en),
    .count (burst_words)
  );

  assign xfifo_oe  = rd_en;
  assign bridge_we = wr_en;

endmodule

// File: rtl/fifo_burst_drain_chk.sv
module fifo_burst_drain_chk #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               xfifo_fill_n,
  input logic               xfifo_low_n,
  input logic               bridge_full,
  input logic               xfifo_oe,
  input logic               bridge_we,
  input logic [COUNT_W-1:0] burst_words
);

  localparam logic [COUNT_W-1:0] CNT_MAX = {COUNT_W{1'b1}};

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!xfifo_oe && !bridge_we && burst_words == '0));

  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!xfifo_oe && !xfifo_fill_n && !bridge_full) |=> (xfifo_oe && bridge_we));

  assert_no_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!xfifo_oe && (xfifo_fill_n || bridge_full)) |=> !xfifo_oe);

  assert_stop_low_R4: assert property (@(posedge clk) disable iff (rst)
    (xfifo_oe && !xfifo_low_n) |=> (!xfifo_oe && !bridge_we));

  assert_stop_full_R5: assert property (@(posedge clk) disable iff (rst)
    (xfifo_oe && bridge_full) |=> (!xfifo_oe && !bridge_we));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (xfifo_oe && xfifo_low_n && !bridge_full) |=> xfifo_oe);

  assert_paired_R7: assert property (@(posedge clk)
    xfifo_oe == bridge_we);

  assert_count_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(bridge_we) |-> (burst_words == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (bridge_we && burst_words != CNT_MAX) |=> (burst_words == $past(burst_words) + 1'b1));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!bridge_we && (xfifo_fill_n || bridge_full)) |=> $stable(burst_words));

  assert_count_sat_R9: assert property (@(posedge clk) disable iff (rst)
    (bridge_we && burst_words == CNT_MAX) |=> (burst_words == CNT_MAX));

endmodule

bind fifo_burst_drain fifo_burst_drain_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfifo_fill_n (xfifo_fill_n),
  .xfifo_low_n  (xfifo_low_n),
  .bridge_full  (bridge_full),
  .xfifo_oe     (xfifo_oe),
  .bridge_we    (bridge_we),
  .burst_words  (burst_words)
);

// File: tb/fifo_burst_drain_bench.sv
module fifo_burst_drain_bench;

  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fill_n = 1'b1;
  logic          low_n  = 1'b1;
  logic          full   = 1'b0;
  logic          oe;
  logic          we;
  logic [CW-1:0] words;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fifo_burst_drain #(.COUNT_W(CW)) u_fifo_burst_drain (
    .clk          (clk),
    .rst          (rst),
    .xfifo_fill_n (fill_n),
    .xfifo_low_n  (low_n),
    .bridge_full  (full),
    .xfifo_oe     (oe),
    .bridge_we    (we),
    .burst_words  (words)
  );

  // Sample on the falling edge: outputs reflect the preceding rising edge.
  task automatic expect_out(string req, logic en_exp, int cnt_exp);
    checks++;
    if (oe !== en_exp || we !== en_exp || int'(words) != cnt_exp) begin
      fails++;
      $display("FAIL %s: oe=%0b we=%0b words=%0d expected en=%0b words=%0d",
               req, oe, we, words, en_exp, cnt_exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic to_idle_inputs();
    fill_n = 1'b1; low_n = 1'b1; full = 1'b0;
  endtask

  // Start a burst and run n further cycles; returns with the strobes high and words==n.
  task automatic open_burst(string req, int n);
    fill_n = 1'b0;
    step();
    expect_out(req, 1'b1, 0);
    fill_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      step();
      expect_out(req, 1'b1, (k > CMAX) ? CMAX : k);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    expect_out("R1", 1'b0, 0);
    rst = 1'b0;
    step();
    expect_out("R1", 1'b0, 0);
  endtask

  task automatic t_no_start();
    to_idle_inputs();
    step(); step();
    expect_out("R3", 1'b0, 0);
    fill_n = 1'b0; full = 1'b1;
    step(); step();
    expect_out("R3", 1'b0, 0);
    fill_n = 1'b1; full = 1'b0; low_n = 1'b0;
    step(); step();
    expect_out("R3", 1'b0, 0);
    to_idle_inputs();
  endtask

  task automatic t_stop_low();
    open_burst("R2 R6 R7", 3);
    low_n = 1'b0;
    step();
    expect_out("R4", 1'b0, 4);
    to_idle_inputs();
    step(); step();
    expect_out("R8", 1'b0, 4);
  endtask

  task automatic t_stop_full();
    open_burst("R2", 2);
    full = 1'b1;
    step();
    expect_out("R5", 1'b0, 3);
    step();
    expect_out("R5", 1'b0, 3);
    to_idle_inputs();
  endtask

  task automatic t_stop_both();
    open_burst("R8", 5);
    full = 1'b1; low_n = 1'b0;
    step();
    expect_out("R5", 1'b0, 6);
    step();
    expect_out("R5", 1'b0, 6);
    to_idle_inputs();
  endtask

  task automatic t_fill_toggles();
    fill_n = 1'b0;
    step();
    expect_out("R6", 1'b1, 0);
    for (int k = 1; k <= 4; k++) begin
      fill_n = k[0];
      step();
      expect_out("R6", 1'b1, k);
    end
    low_n = 1'b0;
    step();
    expect_out("R4", 1'b0, 5);
    to_idle_inputs();
  endtask

  task automatic t_start_with_low();
    fill_n = 1'b0; low_n = 1'b0;
    step();
    expect_out("R10", 1'b1, 0);
    fill_n = 1'b1;
    step();
    expect_out("R10", 1'b0, 1);
    to_idle_inputs();
    step();
  endtask

  task automatic t_saturate();
    open_burst("R9", CMAX + 5);
    expect_out("R9", 1'b1, CMAX);
    low_n = 1'b0;
    step();
    expect_out("R9", 1'b0, CMAX);
    to_idle_inputs();
  endtask

  task automatic t_reset_mid();
    open_burst("R8", 2);
    rst = 1'b1;
    step();
    expect_out("R1", 1'b0, 0);
    rst = 1'b0;
    step();
    expect_out("R1", 1'b0, 0);
  endtask

  initial begin
    step();
    t_reset();
    t_no_start();
    t_stop_low();
    t_stop_full();
    t_stop_both();
    t_fill_toggles();
    t_start_with_low();
    t_saturate();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule